// File: doc/BRIEF.md
# Watch-Mode Power Sequencer

This block sequences the clock and power state of a small microcontroller. It holds the current active operating mode: high-speed, medium-speed or subactive. When the processor asks to sleep, it checks a set of three control bits. If they request the timer-only sleep state, called watch mode here, the block stops the processor and peripheral clocks. The timer clock keeps running, and the output drivers of every I/O port are disabled. Register and memory contents are not touched, because no reset is issued while asleep.

The block leaves watch mode on a qualified wake interrupt or on the synchronous reset input. A wake interrupt qualifies in three ways:

- the non-maskable interrupt always wakes;
- the timer interrupt wakes when it is enabled and the CPU mask is clear;
- each external interrupt pin wakes when its own enable bit is set.

If the low-speed select is set, the block resumes at once in subactive mode. Otherwise it counts out an oscillator settling wait of 2^(n+8) cycles, where n is a 3-bit settling selector. It then resumes in high-speed or medium-speed mode, as chosen by a mode-select input. The selector and the target mode are both captured at the moment of wake. On an interrupt wake, a one-cycle strobe tells the processor to start exception handling.

Top module: `pwr_watch_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to high-speed mode with all clock enables and the port enable at 1 and `irq_start` at 0. Reset wins over any interrupt, and it applies in every state, including watch and settling.
- R2: When `sleep_req` is 1 in an active mode with `sby_en`=1, `direct_xfer`=0 and `tmr_watch`=1, `cur_mode` reads 3 (watch) in the following cycle.
- R3: A sleep request in an active mode with any other combination of those three bits leaves the mode unchanged and the clocks running.
- R4: While `cur_mode` is 3, `cpu_clk_en` and `periph_clk_en` are 0 and `timer_clk_en` is 1. In active modes all three are 1.
- R5: While `cur_mode` is 3, `port_oe_allow` is 0 (ports high-impedance). In active modes it is 1.
- R6: The wake condition is true when any of these holds: `nmi`; `tmr_irq` with `tmr_irq_en`=1 and `cpu_mask`=0; or any bit k of `ext_irq` with bit k of `ext_irq_en` set.
- R7: An external pin whose enable bit is 0, a timer interrupt that is disabled or masked, and a sleep request all leave the block in watch mode.
- R8: A wake with `low_speed_sel`=1 makes `cur_mode` read 2 (subactive) in the next cycle, with `irq_start` high in that cycle.
- R9: A wake with `low_speed_sel`=0 keeps `cur_mode` at 3 for 2^(`settle_sel`+8) further cycles. The mode then becomes 0 (high-speed) if `med_sel` was 0 at wake, or 1 (medium-speed) if it was 1.
- R10: `irq_start` is high for exactly one cycle, only when an interrupt wake completes. It never follows a reset.
- R11: `cur_mode` encodes 0 = high-speed, 1 = medium-speed, 2 = subactive, 3 = watch or settling.
- R12: During settling, changes to wake inputs, `sleep_req`, `low_speed_sel`, `med_sel` and `settle_sel` do not alter the length of the wait or the resume mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset (reset pin) |
| sleep_req | input | 1 | Processor sleep request |
| sby_en | input | 1 | Standby select bit |
| direct_xfer | input | 1 | Direct mode-transfer bit (must be 0 for watch) |
| tmr_watch | input | 1 | Timer watch-select bit |
| low_speed_sel | input | 1 | Resume in subactive mode when 1 |
| med_sel | input | 1 | Resume in medium-speed (1) or high-speed (0) |
| settle_sel | input | 3 | Settling selector n, wait 2^(n+8) cycles |
| nmi | input | 1 | Non-maskable interrupt |
| tmr_irq | input | 1 | Timer interrupt request |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| cpu_mask | input | 1 | CPU interrupt mask for the timer interrupt |
| ext_irq | input | 4 | External interrupt pins |
| ext_irq_en | input | 4 | Per-pin wake enables |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| timer_clk_en | output | 1 | Timer clock enable |
| port_oe_allow | output | 1 | Port output-enable gate, 0 forces high-impedance |
| irq_start | output | 1 | One-cycle exception-start strobe |
| cur_mode | output | 2 | Current mode code |

## Verification
The assertions assume that every input is synchronous to `clk` and that `sleep_req` and the wake sources are levels sampled once per cycle. They also assume the settling base exponent is at least one, so that a freshly loaded count is never zero. The stimulus drives all inputs on the falling edge, holding each one stable across the rising edge. During settling it deliberately disturbs the wake sources, the sleep request and the resume selectors, to show that the values captured at wake time are the ones used. Settling selectors 0 and 1 keep each wait short enough for the run.

// File: rtl/pwr_watch_pkg.sv
`timescale 1ns/1ps
// Shared types for the watch-mode power sequencer.
// Assumes: mode codes are visible at the top-level port, so their values are fixed.
package pwr_watch_pkg;
    typedef enum logic [1:0] {
        MODE_HIGH  = 2'd0,
        MODE_MED   = 2'd1,
        MODE_SUB   = 2'd2,
        MODE_WATCH = 2'd3
    } pwr_mode_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_WATCH  = 2'd1,
        ST_SETTLE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pwr_wake_qual.sv
`timescale 1ns/1ps
// Wake qualification: merges the wake sources into one request.
// NMI is unconditional; the timer needs its enable and a clear CPU mask;
// each external pin needs its own enable. Assumes synchronous inputs.
module pwr_wake_qual #(
    parameter int NIRQ = 4
) (
    input  logic            nmi,
    input  logic            tmr_irq,
    input  logic            tmr_irq_en,
    input  logic            cpu_mask,
    input  logic [NIRQ-1:0] ext_irq,
    input  logic [NIRQ-1:0] ext_irq_en,
    output logic            wake
);
    logic [NIRQ-1:0] pin_hit;
    logic            tmr_hit;

    // One gate per external pin: it counts only when enabled.
    for (genvar k = 0; k < NIRQ; k++) begin : g_pin
        assign pin_hit[k] = ext_irq[k] & ext_irq_en[k];
    end

    // Timer request counts when enabled and not masked by the CPU.
    assign tmr_hit = tmr_irq & tmr_irq_en & ~cpu_mask;

    // Combine all qualified sources.
    assign wake = nmi | tmr_hit | (|pin_hit);

    // Checks on source qualification.
    always_comb begin
        p_nmi_wakes_r6: assert (!nmi || wake);
        p_masked_quiet_r7: assert (nmi || (|(ext_irq & ext_irq_en)) || !(tmr_irq && cpu_mask) || !wake);
    end
endmodule

// File: rtl/pwr_settle_timer.sv
`timescale 1ns/1ps
// Oscillator settling down-counter. A load sets it to 2^(sel+BASE)-1;
// it then counts to zero, where done is reported. Assumes BASE >= 1.
module pwr_settle_timer #(
    parameter int STS_W       = 3,
    parameter int SETTLE_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [STS_W-1:0] sel,
    output logic             done
);
    localparam int CNT_W = SETTLE_BASE + (1 << STS_W) - 1;
    localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;

    // Load value: wait length minus one.
    always_comb span = (ONE << (int'(sel) + SETTLE_BASE)) - ONE;

    // Count register: load on wake, otherwise step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= span[CNT_W-1:0];
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    p_load_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
    p_step_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
// Mode state machine: active run, watch, settling. It captures the resume
// mode at wake and raises a one-cycle start strobe when a wake completes.
// Assumes the settling timer reports done only after a load has elapsed.
module pwr_mode_fsm
    import pwr_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       entry_ok,
    input  logic       wake,
    input  logic       low_speed_sel,
    input  logic       med_sel,
    input  logic       settle_done,
    output logic       settle_load,
    output logic       asleep,
    output logic       irq_start,
    output logic [1:0] cur_mode
);
    seq_state_e state;
    pwr_mode_e  mode;
    pwr_mode_e  target;

    // Sequencer: reset first, then the per-state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            mode      <= MODE_HIGH;
            target    <= MODE_HIGH;
            irq_start <= 1'b0;
        end else begin
            irq_start <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (sleep_req && entry_ok) state <= ST_WATCH;
                end
                ST_WATCH: begin
                    if (wake) begin
                        if (low_speed_sel) begin
                            mode      <= MODE_SUB;
                            state     <= ST_RUN;
                            irq_start <= 1'b1;
                        end else begin
                            target <= med_sel ? MODE_MED : MODE_HIGH;
                            state  <= ST_SETTLE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (settle_done) begin
                        mode      <= target;
                        state     <= ST_RUN;
                        irq_start <= 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Start the settling count on a full-speed wake.
    assign settle_load = (state == ST_WATCH) && wake && !low_speed_sel;
    // Clocks are held off in watch and settling.
    assign asleep      = (state != ST_RUN);
    // Report watch while asleep, the stored mode otherwise.
    assign cur_mode    = asleep ? MODE_WATCH : mode;

    p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && entry_ok) |=> cur_mode == MODE_WATCH);
    p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !entry_ok) |=> (state == ST_RUN && cur_mode == $past(cur_mode)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && !wake) |=> state == ST_WATCH);
    p_sub_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && wake && low_speed_sel) |=> (cur_mode == MODE_SUB && irq_start));
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |=> !irq_start);
    p_settle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !settle_done) |=> state == ST_SETTLE);
endmodule

// File: rtl/pwr_watch_ctrl.sv
`timescale 1ns/1ps
// Watch-mode power sequencer top. It qualifies wake sources, runs the mode
// state machine and the settling timer, and drives the clock and port gates.
// Assumes all inputs are synchronous to clk; rst_n is the reset pin.
module pwr_watch_ctrl #(
    parameter int NIRQ        = 4,
    parameter int STS_W       = 3,
    parameter int SETTLE_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             sby_en,
    input  logic             direct_xfer,
    input  logic             tmr_watch,
    input  logic             low_speed_sel,
    input  logic             med_sel,
    input  logic [STS_W-1:0] settle_sel,
    input  logic             nmi,
    input  logic             tmr_irq,
    input  logic             tmr_irq_en,
    input  logic             cpu_mask,
    input  logic [NIRQ-1:0]  ext_irq,
    input  logic [NIRQ-1:0]  ext_irq_en,
    output logic             cpu_clk_en,
    output logic             periph_clk_en,
    output logic             timer_clk_en,
    output logic             port_oe_allow,
    output logic             irq_start,
    output logic [1:0]       cur_mode
);
    logic wake;
    logic entry_ok;
    logic settle_load;
    logic settle_done;
    logic asleep;

    // Watch entry needs standby on, direct transfer off, timer watch on.
    assign entry_ok = sby_en & ~direct_xfer & tmr_watch;

    pwr_wake_qual #(.NIRQ(NIRQ)) u_wake (
        .nmi        (nmi),
        .tmr_irq    (tmr_irq),
        .tmr_irq_en (tmr_irq_en),
        .cpu_mask   (cpu_mask),
        .ext_irq    (ext_irq),
        .ext_irq_en (ext_irq_en),
        .wake       (wake)
    );

    pwr_settle_timer #(.STS_W(STS_W), .SETTLE_BASE(SETTLE_BASE)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (settle_load),
        .sel   (settle_sel),
        .done  (settle_done)
    );

    pwr_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_req     (sleep_req),
        .entry_ok      (entry_ok),
        .wake          (wake),
        .low_speed_sel (low_speed_sel),
        .med_sel       (med_sel),
        .settle_done   (settle_done),
        .settle_load   (settle_load),
        .asleep        (asleep),
        .irq_start     (irq_start),
        .cur_mode      (cur_mode)
    );

    // Clock and port gates follow the asleep flag; the timer never stops.
    assign cpu_clk_en    = ~asleep;
    assign periph_clk_en = ~asleep;
    assign timer_clk_en  = 1'b1;
    assign port_oe_allow = ~asleep;

    p_watch_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd3) |-> (!cpu_clk_en && !periph_clk_en && timer_clk_en));
    p_ports_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd3) |-> !port_oe_allow);
    p_strobe_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_start |-> (cur_mode != 2'd3 && $past(cur_mode) == 2'd3));
endmodule

// File: tb/test_pwr_watch_ctrl.sv
`timescale 1ns/1ps
// Bench: a behavioural model updated on each rising edge, compared on each
// falling edge, plus directed checks per requirement.
module test_pwr_watch_ctrl;
    localparam int NIRQ = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n, sleep_req, sby_en, direct_xfer, tmr_watch;
    logic low_speed_sel, med_sel, nmi, tmr_irq, tmr_irq_en, cpu_mask;
    logic [2:0] settle_sel;
    logic [NIRQ-1:0] ext_irq, ext_irq_en;
    logic cpu_clk_en, periph_clk_en, timer_clk_en, port_oe_allow, irq_start;
    logic [1:0] cur_mode;

    pwr_watch_ctrl i_pwr_watch_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sby_en(sby_en),
        .direct_xfer(direct_xfer), .tmr_watch(tmr_watch),
        .low_speed_sel(low_speed_sel), .med_sel(med_sel), .settle_sel(settle_sel),
        .nmi(nmi), .tmr_irq(tmr_irq), .tmr_irq_en(tmr_irq_en), .cpu_mask(cpu_mask),
        .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .timer_clk_en(timer_clk_en), .port_oe_allow(port_oe_allow),
        .irq_start(irq_start), .cur_mode(cur_mode)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: 0 run, 1 watch, 2 settling; m_left counts settle edges.
    int m_state = 0, m_mode = 0, m_target = 0, m_left = 0;
    bit m_strobe = 1'b0;

    always @(posedge clk) begin
        bit wk;
        wk = nmi || (tmr_irq && tmr_irq_en && !cpu_mask) || ((ext_irq & ext_irq_en) != 0);
        if (!rst_n) begin
            m_state = 0; m_mode = 0; m_target = 0; m_left = 0; m_strobe = 1'b0;
        end else begin
            m_strobe = 1'b0;
            if (m_state == 0) begin
                if (sleep_req && sby_en && !direct_xfer && tmr_watch) m_state = 1;
            end else if (m_state == 1) begin
                if (wk) begin
                    if (low_speed_sel) begin
                        m_mode = 2; m_state = 0; m_strobe = 1'b1;
                    end else begin
                        m_target = med_sel ? 1 : 0;
                        m_left   = 1 << (settle_sel + 8);
                        m_state  = 2;
                    end
                end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    m_mode = m_target; m_state = 0; m_strobe = 1'b1;
                end
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R11 cur_mode", int'(cur_mode), (m_state != 0) ? 3 : m_mode);
            check("R4 cpu clock", int'(cpu_clk_en), int'(m_state == 0));
            check("R4 periph clock", int'(periph_clk_en), int'(m_state == 0));
            check("R4 timer clock", int'(timer_clk_en), 1);
            check("R5 port enable", int'(port_oe_allow), int'(m_state == 0));
            check("R10 strobe", int'(irq_start), int'(m_strobe));
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog (all requirements): got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_watch();
        sleep_req = 1; sby_en = 1; direct_xfer = 0; tmr_watch = 1;
        tick();
        sleep_req = 0;
        check("R2 watch entry", int'(cur_mode), 3);
    endtask

    initial begin
        rst_n = 0; sleep_req = 0; sby_en = 0; direct_xfer = 0; tmr_watch = 0;
        low_speed_sel = 0; med_sel = 0; settle_sel = 0; nmi = 0; tmr_irq = 0;
        tmr_irq_en = 0; cpu_mask = 0; ext_irq = '0; ext_irq_en = '0;
        tick(2);
        cmp_on = 1'b1;
        tick();
        check("R1 reset mode", int'(cur_mode), 0);
        check("R1 reset cpu clock", int'(cpu_clk_en), 1);
        check("R1 reset strobe", int'(irq_start), 0);
        rst_n = 1;
        tick();

        // R3: sleep without the full watch condition.
        sleep_req = 1; sby_en = 0; tmr_watch = 1;
        tick(); check("R3 standby off", int'(cur_mode), 0);
        sby_en = 1; direct_xfer = 1;
        tick(); check("R3 direct set", int'(cur_mode), 0);
        direct_xfer = 0; tmr_watch = 0;
        tick(); check("R3 timer bit off", int'(cpu_clk_en), 1);
        sleep_req = 0;
        tick();

        // R7: unqualified sources keep watch.
        go_watch();
        ext_irq = 4'b0010; ext_irq_en = 4'b1101;
        tick(2); check("R7 disabled pin", int'(cur_mode), 3);
        ext_irq = '0; tmr_irq = 1; tmr_irq_en = 1; cpu_mask = 1;
        tick(2); check("R7 masked timer", int'(cur_mode), 3);
        cpu_mask = 0; tmr_irq_en = 0;
        tick(2); check("R7 disabled timer", int'(cur_mode), 3);
        tmr_irq = 0; sleep_req = 1;
        tick(2); check("R7 sleep in watch", int'(port_oe_allow), 0);
        sleep_req = 0;

        // R8 and R6: enabled pin wakes to subactive.
        low_speed_sel = 1; ext_irq = 4'b0100; ext_irq_en = 4'b0100;
        tick();
        ext_irq = '0;
        check("R8 subactive", int'(cur_mode), 2);
        check("R8 strobe", int'(irq_start), 1);
        tick();
        check("R10 strobe one cycle", int'(irq_start), 0);
        check("R6 pin wake held", int'(cur_mode), 2);

        // R9 and R12: NMI wake to medium with selector 0, inputs disturbed.
        go_watch();
        low_speed_sel = 0; med_sel = 1; settle_sel = 3'd0; nmi = 1;
        tick();
        check("R9 settling", int'(cur_mode), 3);
        sleep_req = 1; low_speed_sel = 1; med_sel = 0; settle_sel = 3'd7;
        tick(254);
        nmi = 0; sleep_req = 0; low_speed_sel = 0; settle_sel = 3'd0;
        tick();
        check("R12 still settling", int'(cur_mode), 3);
        tick();
        check("R9 medium resume", int'(cur_mode), 1);
        check("R10 settle strobe", int'(irq_start), 1);
        tick();

        // R9 and R6: timer wake to high-speed with selector 1.
        go_watch();
        tmr_irq = 1; tmr_irq_en = 1; cpu_mask = 0; med_sel = 0; settle_sel = 3'd1;
        tick();
        tmr_irq = 0;
        tick(511);
        check("R9 long settling", int'(cur_mode), 3);
        tick();
        check("R6 timer wake high", int'(cur_mode), 0);
        check("R10 strobe after timer", int'(irq_start), 1);
        tick();

        // R1: reset in watch beats a pending NMI.
        go_watch();
        nmi = 1; rst_n = 0;
        tick();
        nmi = 0; rst_n = 1;
        check("R1 reset in watch", int'(cur_mode), 0);
        check("R10 no strobe on reset", int'(irq_start), 0);
        tick();

        // R1: reset during settling.
        go_watch();
        nmi = 1; low_speed_sel = 0; settle_sel = 3'd0;
        tick();
        nmi = 0;
        tick(10);
        rst_n = 0;
        tick();
        rst_n = 1;
        check("R1 reset in settle", int'(cur_mode), 0);
        tick(3);
        check("R10 no late strobe", int'(irq_start), 0);
        check("R1 clocks back", int'(periph_clk_en), 1);

        finish_run();
    end
endmodule